// File: doc/BRIEF.md
# PN and Pattern Link Monitor

This block sits behind the capture path of a 16-bit sample link and checks every received word against a known test sequence. The link can then be proven sound before real data is stored. A two-bit mode input selects one of three checks. The first is a short pseudo-random sequence built on x^9 + x^5 + 1. The second is a long pseudo-random sequence built on x^23 + x^18 + 1. The third compares each word with a fixed 16-bit constant supplied on a pattern input.

In the two pseudo-random modes the monitor needs no seed. It takes the received words as its generator state, predicts the next 16 sequence bits and compares them with the word that arrives. The sender inverts the top bit of every word and leaves the other 15 bits untouched. The monitor restores that bit before the word enters its history or the comparison. Sync status is held in a flag with hysteresis. A sticky error flag records any mismatch seen while the link is believed to be in sync, and it stays set until it is cleared.

Top module: `pnmon_checker`

## Requirements
- R1: While reset is held and right after it, out_of_sync_o is 1, err_sticky_o is 0 and mismatch_o is 0.
- R2: Mode 2'b00 uses the short sequence. Stream bit n equals bit n-9 XOR bit n-5. Each word carries 16 consecutive bits, oldest bit in bit 15, and bit 15 is then inverted. After a restart the first two valid words only load history. The following 16 matching words clear out_of_sync_o on the 16th, and not before.
- R3: Mode 2'b01 works the same way with the long sequence, where bit n equals bit n-23 XOR bit n-18.
- R4: In both sequence modes bit 15 of each received word is inverted before it is compared or stored. A stream sent without that inversion mismatches on every compared word and never gains sync.
- R5: A compared word that mismatches while out_of_sync_o is 0 sets err_sticky_o. Mismatches seen while out of sync never set it. Fewer than 16 consecutive mismatches leave out_of_sync_o at 0.
- R6: A one-cycle pulse on err_clear_i clears err_sticky_o. If a new error arrives in the same cycle, the flag stays set.
- R7: While in sync, 16 consecutive mismatching compared words set out_of_sync_o on the 16th, and 15 do not. Any match resets the run count.
- R8: Modes 2'b10 and 2'b11 compare the raw received word with pattern_i, with no bit inversion and no priming words.
- R9: A change of mode_i restarts the monitor. out_of_sync_o goes to 1, the run count clears and the history must be loaded again. The sample in that cycle is discarded.
- R10: Cycles with valid_i low change nothing, whatever is on data_i.
- R11: mismatch_o is 1 for exactly one cycle after each compared word that mismatches. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 short sequence, 01 long sequence, 10/11 fixed pattern |
| pattern_i | input | 16 | Constant used in pattern mode |
| valid_i | input | 1 | data_i carries a sample this cycle |
| data_i | input | 16 | Received sample word |
| err_clear_i | input | 1 | Clears the sticky error flag |
| mismatch_o | output | 1 | Pulse: the last compared word differed |
| out_of_sync_o | output | 1 | Monitor not locked to the stream |
| err_sticky_o | output | 1 | A mismatch was seen while in sync |

## Verification
Clean short-sequence and long-sequence streams, each from a random seed, show that the monitor locks after exactly two priming words plus sixteen matches. A long-sequence stream sent without top-bit inversion proves that the inversion step is really applied, because it must mismatch on every word. A single corrupted word in a locked stream separates the sticky error from loss of sync. In pattern mode, runs of 15 and 16 wrong words pin down the exit threshold, and a word with only the top bit flipped shows that pattern mode inverts nothing. Random data on idle cycles and random gaps between words check that only valid samples count.

// File: rtl/pnmon_pkg.sv
package pnmon_pkg;

  typedef enum logic [1:0] {
    MODE_PN_SHORT = 2'b00,
    MODE_PN_LONG  = 2'b01,
    MODE_PAT      = 2'b10,
    MODE_PAT_ALT  = 2'b11
  } mode_e;

  // feedback lags of the two recurrences (bit n = bit n-A xor bit n-B)
  localparam int SHORT_LAG_A = 9;
  localparam int SHORT_LAG_B = 5;
  localparam int LONG_LAG_A  = 23;
  localparam int LONG_LAG_B  = 18;

  function automatic logic mode_is_pattern(mode_e m);
    return (m == MODE_PAT) || (m == MODE_PAT_ALT);
  endfunction

endpackage

// File: rtl/pnmon_rst_sync.sv
module pnmon_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pnmon_predict.sv
module pnmon_predict
  import pnmon_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  mode_e         mode_i,
  input  logic [DW-1:0] pattern_i,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  output logic          cmp_valid_o,
  output logic          match_o
);
  localparam int HW = 2 * DW;
  localparam int PRIME_WORDS = (LONG_LAG_A + DW - 1) / DW;
  localparam int PW = $clog2(PRIME_WORDS + 1);
  localparam logic [DW-1:0] TOP_MASK = {1'b1, {(DW-1){1'b0}}};

  logic [HW-1:0] hist_q, hist_d;
  logic [PW-1:0] prime_q, prime_d;
  logic [DW-1:0] rx_word;
  logic [DW-1:0] exp_word;
  logic          pat_mode;
  logic          primed;

  // predict next DW stream bits; hist[0] holds the most recent bit
  function automatic logic [DW-1:0] predict(logic [HW-1:0] h, logic long_seq);
    logic [HW-1:0] r;
    logic [DW-1:0] w;
    logic          nb;
    r = h;
    w = '0;
    for (int k = 0; k < DW; k++) begin
      nb = long_seq ? (r[LONG_LAG_A-1] ^ r[LONG_LAG_B-1])
                    : (r[SHORT_LAG_A-1] ^ r[SHORT_LAG_B-1]);
      r  = {r[HW-2:0], nb};
      w  = {w[DW-2:0], nb};
    end
    return w;
  endfunction

  assign pat_mode = mode_is_pattern(mode_i);
  assign primed   = (prime_q == PW'(PRIME_WORDS));
  assign rx_word  = pat_mode ? data_i : (data_i ^ TOP_MASK);
  assign exp_word = pat_mode ? pattern_i : predict(hist_q, mode_i == MODE_PN_LONG);

  assign cmp_valid_o = valid_i && !restart_i && (pat_mode || primed);
  assign match_o     = (rx_word == exp_word);

  always_comb begin
    hist_d  = hist_q;
    prime_d = prime_q;
    if (restart_i) begin
      hist_d  = '0;
      prime_d = '0;
    end else if (valid_i) begin
      hist_d = {hist_q[DW-1:0], rx_word};
      if (!primed) prime_d = prime_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      prime_q <= '0;
    end else begin
      hist_q  <= hist_d;
      prime_q <= prime_d;
    end
  end

  // R2: priming count never runs past the history depth
  p_prime_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prime_q <= PW'(PRIME_WORDS));

  // R10: idle cycles leave the history untouched
  p_hist_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i && !restart_i) |=> $stable(hist_q) && $stable(prime_q));

endmodule

// File: rtl/pnmon_sync.sv
module pnmon_sync #(
  parameter int RUN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic cmp_valid_i,
  input  logic match_i,
  input  logic err_clear_i,
  output logic mismatch_o,
  output logic oos_o,
  output logic err_o
);
  localparam int CW = $clog2(RUN + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          oos_q, oos_d;
  logic          err_q, err_d;
  logic          mm_q, mm_d;
  logic          against;
  logic          err_set;

  // a result that argues for leaving the current state
  assign against = oos_q ? match_i : !match_i;
  assign err_set = cmp_valid_i && !restart_i && !match_i && !oos_q;

  always_comb begin
    cnt_d = cnt_q;
    oos_d = oos_q;
    mm_d  = 1'b0;
    if (restart_i) begin
      cnt_d = '0;
      oos_d = 1'b1;
    end else if (cmp_valid_i) begin
      mm_d = !match_i;
      if (against) begin
        if (cnt_q == CW'(RUN - 1)) begin
          cnt_d = '0;
          oos_d = !oos_q;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_comb begin
    err_d = err_q;
    if (err_clear_i) err_d = 1'b0;
    if (err_set)     err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      oos_q <= 1'b1;
      err_q <= 1'b0;
      mm_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      oos_q <= oos_d;
      err_q <= err_d;
      mm_q  <= mm_d;
    end
  end

  assign mismatch_o = mm_q;
  assign oos_o      = oos_q;
  assign err_o      = err_q;

  // R5: an in-sync mismatch always leaves the error flag set
  p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid_i && !restart_i && !match_i && !oos_q) |=> err_q);

  // R6: a clear with no new error empties the flag
  p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clear_i && !(cmp_valid_i && !restart_i && !match_i && !oos_q)) |=> !err_q);

  // R11: no pulse without a compared word
  p_mm_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid_i |=> !mm_q);

  // R7: run counter stays below the threshold
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(RUN));

  // R7: sync is only lost on a mismatch or a restart
  p_oos_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oos_q) |-> $past(restart_i || (cmp_valid_i && !match_i)));

endmodule

// File: rtl/pnmon_checker.sv
module pnmon_checker
  import pnmon_pkg::*;
#(
  parameter int DW       = 16,
  parameter int SYNC_RUN = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] pattern_i,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic          err_clear_i,
  output logic          mismatch_o,
  output logic          out_of_sync_o,
  output logic          err_sticky_o
);
  logic  rst_n_s;
  mode_e mode_cur;
  mode_e mode_q, mode_d;
  logic  restart;
  logic  cmp_valid;
  logic  match;

  pnmon_rst_sync #(.STAGES(2)) u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_s)
  );

  assign mode_cur = mode_e'(mode_i);
  assign restart  = (mode_cur != mode_q);

  always_comb mode_d = mode_cur;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) mode_q <= MODE_PN_SHORT;
    else          mode_q <= mode_d;
  end

  pnmon_predict #(.DW(DW)) u_pred (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .restart_i   (restart),
    .mode_i      (mode_cur),
    .pattern_i   (pattern_i),
    .valid_i     (valid_i),
    .data_i      (data_i),
    .cmp_valid_o (cmp_valid),
    .match_o     (match)
  );

  pnmon_sync #(.RUN(SYNC_RUN)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .restart_i   (restart),
    .cmp_valid_i (cmp_valid),
    .match_i     (match),
    .err_clear_i (err_clear_i),
    .mismatch_o  (mismatch_o),
    .oos_o       (out_of_sync_o),
    .err_o       (err_sticky_o)
  );

  // R9: a mode change always drops sync
  p_restart_oos_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    restart |=> out_of_sync_o);

endmodule

// File: tb/pnmon_checker_tb_top.sv
module pnmon_checker_tb_top;
  logic        clk;
  logic        rst_n;
  logic [1:0]  mode_i;
  logic [15:0] pattern_i;
  logic        valid_i;
  logic [15:0] data_i;
  logic        err_clear_i;
  logic        mismatch_o;
  logic        out_of_sync_o;
  logic        err_sticky_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [22:0] st;

  pnmon_checker dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .pattern_i(pattern_i),
    .valid_i(valid_i), .data_i(data_i), .err_clear_i(err_clear_i),
    .mismatch_o(mismatch_o), .out_of_sync_o(out_of_sync_o),
    .err_sticky_o(err_sticky_o)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench model of the sequence recurrence, oldest bit to bit 15
  function automatic logic [15:0] next_seq(bit long_seq);
    logic [15:0] w = '0;
    logic nb;
    for (int k = 0; k < 16; k++) begin
      nb = long_seq ? (st[22] ^ st[17]) : (st[8] ^ st[4]);
      st = {st[21:0], nb};
      w  = {w[14:0], nb};
    end
    return w;
  endfunction

  task automatic idle_gap();
    int n = $urandom_range(0, 2);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 0;
      data_i  = 16'($urandom);
    end
  endtask

  task automatic send(logic [15:0] w, bit clr, output bit mm);
    @(negedge clk);
    valid_i = 1; data_i = w; err_clear_i = clr;
    @(negedge clk);
    valid_i = 0; err_clear_i = 0; data_i = 16'($urandom);
    mm = mismatch_o;
    idle_gap();
  endtask

  task automatic set_mode(logic [1:0] m);
    @(negedge clk);
    valid_i = 0; mode_i = m;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk); err_clear_i = 1;
    @(negedge clk); err_clear_i = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    bit mm;
    int mmcnt;
    logic [15:0] w, pat;
    void'($urandom(32'd2025));
    rst_n = 0; mode_i = 2'b00; pattern_i = 0; valid_i = 0; data_i = 0; err_clear_i = 0;
    repeat (3) @(negedge clk);
    check("R1 oos in reset", out_of_sync_o, 1);
    check("R1 err in reset", err_sticky_o, 0);
    check("R1 mismatch in reset", mismatch_o, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 oos after reset", out_of_sync_o, 1);

    // R2 short sequence lock, with idle gaps of random data (R10)
    st = 23'($urandom) | 23'h1;
    mmcnt = 0;
    for (int i = 0; i < 17; i++) begin
      send(next_seq(0) ^ 16'h8000, 0, mm); mmcnt += mm;
    end
    check("R2 still oos after 15 matches", out_of_sync_o, 1);
    send(next_seq(0) ^ 16'h8000, 0, mm); mmcnt += mm;
    check("R2 locked after 16 matches", out_of_sync_o, 0);
    check("R10 no mismatch across idle gaps", mmcnt, 0);
    check("R5 no error on clean stream", err_sticky_o, 0);

    // R5/R11 single corruption while locked
    send(next_seq(0) ^ 16'h8000 ^ 16'h0100, 0, mm);
    check("R11 mismatch pulse", mm, 1);
    @(negedge clk);
    check("R11 pulse one cycle", mismatch_o, 0);
    check("R5 err set", err_sticky_o, 1);
    for (int i = 0; i < 5; i++) send(next_seq(0) ^ 16'h8000, 0, mm);
    check("R5 sync kept", out_of_sync_o, 0);
    check("R5 err sticky", err_sticky_o, 1);
    pulse_clear();
    check("R6 err cleared", err_sticky_o, 0);
    send(next_seq(0) ^ 16'h8000, 0, mm);
    check("R6 stays clear", err_sticky_o, 0);

    // R9 mode change drops sync; R4 raw long stream never locks
    set_mode(2'b01);
    check("R9 oos after mode change", out_of_sync_o, 1);
    st = 23'($urandom) | 23'h1;
    mmcnt = 0;
    for (int i = 0; i < 40; i++) begin
      send(next_seq(1), 0, mm); mmcnt += mm;
    end
    check("R4 every compared raw word mismatches", mmcnt, 38);
    check("R4 never locks", out_of_sync_o, 1);
    check("R5 no error while oos", err_sticky_o, 0);

    // R3 proper long stream after a clean restart
    set_mode(2'b10);
    set_mode(2'b01);
    st = 23'($urandom) | 23'h1;
    for (int i = 0; i < 17; i++) send(next_seq(1) ^ 16'h8000, 0, mm);
    check("R3 still oos after 15 matches", out_of_sync_o, 1);
    send(next_seq(1) ^ 16'h8000, 0, mm);
    check("R3 locked", out_of_sync_o, 0);

    // R8/R7 pattern mode
    pat = 16'($urandom);
    pattern_i = pat;
    set_mode(2'b10);
    check("R9 oos on pattern entry", out_of_sync_o, 1);
    for (int i = 0; i < 15; i++) send(pat, 0, mm);
    check("R8 oos after 15", out_of_sync_o, 1);
    send(pat, 0, mm);
    check("R8 lock after 16, no priming", out_of_sync_o, 0);
    send(pat ^ 16'h8000, 0, mm);
    check("R8 top-bit flip mismatches", mm, 1);
    send(pat, 0, mm);
    check("R8 match resets run", mm, 0);
    for (int i = 0; i < 15; i++) begin
      w = 16'($urandom);
      if (w == pat) w = ~pat;
      send(w, 0, mm);
    end
    check("R7 15 mismatches keep sync", out_of_sync_o, 0);
    check("R5 err from pattern mismatch", err_sticky_o, 1);
    send(~pat, 0, mm);
    check("R7 16 mismatches lose sync", out_of_sync_o, 1);

    // R6 clear and set together; mode 11 also pattern
    set_mode(2'b11);
    for (int i = 0; i < 16; i++) send(pat, 0, mm);
    check("R8 mode 11 locks on pattern", out_of_sync_o, 0);
    pulse_clear();
    check("R6 cleared before collision", err_sticky_o, 0);
    send(~pat, 1, mm);
    check("R6 set wins over clear", err_sticky_o, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule